// File: doc/BRIEF.md
# Indirect Memory Access Register Port

This block gives a host an 8-bit register window into a 24-bit byte-addressed local memory and into the control of a four-channel adapter. The host loads a 24-bit pointer one byte at a time. It then moves bytes through one of two data registers. The first leaves the pointer where it is. The second advances the pointer by one after each access, so a block of bytes can be streamed without reloading the address. Each data access becomes one request on a synchronous request/acknowledge memory port. `host_busy` is high while that request is outstanding.

A channel-select register picks which of the four channels the channel control register reaches. Each channel has the following:
- a reset hold bit and a halt hold bit;
- an adapter-to-host interrupt flag, which the adapter raises and the host clears by writing a one;
- a host-to-adapter doorbell, which the host raises and the adapter's acknowledge clears;
- an interrupt enable;
- a 3-bit host interrupt-line code.

The upper nibble of the select register reads back the interrupt flags of all four channels at once.

The access sequencer has three states:
- `ST_IDLE` accepts host strobes. A write to a data register goes to `ST_MEM_WR`. A read of a data register goes to `ST_MEM_RD`. Any other strobe is handled in place.
- `ST_MEM_RD` and `ST_MEM_WR` hold the memory request until `mem_ack`, then return to `ST_IDLE`.

Top module: `ind_mem_port`

## Requirements
- R1: Register 0 reads 0xA4. Register 7 and registers 9 to 15 read 0x00, and writes to them change nothing.
- R2: Registers 2, 3 and 4 write and read back pointer bits 7..0, 15..8 and 23..16. The pointer resets to 0.
- R3: A read or write of register 5 accesses memory at the pointer and leaves the pointer unchanged.
- R4: A read or write of register 6 accesses memory at the pointer and then adds one to the pointer. 0xFFFFFF wraps to 0x000000.
- R5: While a memory request is outstanding, the following hold:
  - `host_busy` is 1.
  - `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable until `mem_ack`.
  - Host strobes are ignored.
- R6: Bit 7 of register 1 is the selected channel's reset hold, driven on `chan_reset`. It resets to 1 on every channel, and writing it affects only the selected channel.
- R7: Bit 6 of register 1 is the selected channel's adapter-to-host flag.
  - A pulse on `a2h_raise` sets it.
  - A host write with bit 6 = 1 clears it, and a write with bit 6 = 0 leaves it.
  - If a raise and a clear arrive in the same cycle, the raise wins.
- R8: Bit 5 of register 1 is the selected channel's doorbell, driven on `h2a_irq`.
  - A host write with bit 5 = 1 sets it, and a write with bit 5 = 0 leaves it.
  - A pulse on `h2a_seen` clears it, after which it reads 0.
- R9: Register 1 holds the following read/write fields:
  - bit 4 is halt, driven on `chan_halt`;
  - bit 3 is the interrupt enable;
  - bits 2..0 are the line code (000 means disabled).

  `host_irq[i]` is 1 exactly when channel i's flag, its enable and a non-zero line code are all present.
- R10: Bits 1..0 of register 8 select the channel that register 1 reaches. They reset to 0 and read back. Bits 3..2 read 0.
- R11: Bits 7..4 of register 8 read the adapter-to-host flags of channels 3..0 (bit 4+i is channel i). Writes to those bits are ignored, so a flag is cleared only through register 1.
- R12: A register read (any register but 5 and 6) presents its value on `host_rdata` from the clock edge that samples `host_rd`. A data-register read presents the memory byte from the edge that samples `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_rdata | output | 8 | Registered read data |
| host_busy | output | 1 | Memory access outstanding |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| a2h_raise | input | 4 | Per-channel adapter-to-host interrupt set pulse |
| h2a_seen | input | 4 | Per-channel doorbell acknowledge pulse |
| chan_reset | output | 4 | Per-channel reset hold |
| chan_halt | output | 4 | Per-channel halt hold |
| h2a_irq | output | 4 | Per-channel host-to-adapter doorbell |
| host_irq | output | 4 | Per-channel gated host interrupt |

## Verification
The hardest cases to reach are the ones where two sources meet in the same cycle.
- **Raise against clear.** The bench drives an `a2h_raise` pulse on the same clock edge as a host clear of the same channel's flag. It then reads the flag back through register 1.
- **Strobe while busy.** The bench issues a host write to an address register while a data read is still waiting for `mem_ack`. While the request is outstanding it confirms `host_busy` and `mem_addr`. It then reads the address register back to show it did not change.
- **Pointer wrap.** The bench loads 0xFFFFFF, writes through the incrementing register and reads all three pointer bytes back as zero.

// File: rtl/imp_pkg.sv
package imp_pkg;

    localparam int BYTE_W = 8;

    localparam logic [3:0] OFF_ID       = 4'd0;
    localparam logic [3:0] OFF_CHAN     = 4'd1;
    localparam logic [3:0] OFF_ADDR0    = 4'd2;
    localparam logic [3:0] OFF_DATA     = 4'd5;
    localparam logic [3:0] OFF_DATA_INC = 4'd6;
    localparam logic [3:0] OFF_ADP      = 4'd8;

    localparam logic [7:0] ID_VALUE = 8'hA4;

    // Register 1 bit positions.
    localparam int B_RST  = 7;
    localparam int B_A2H  = 6;
    localparam int B_H2A  = 5;
    localparam int B_HALT = 4;
    localparam int B_IEN  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MEM_RD = 2'd1,
        ST_MEM_WR = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic       rst;
        logic       halt;
        logic       irq_en;
        logic [2:0] line_sel;
    } chan_cfg_t;

endpackage

// File: rtl/imp_addr_ptr.sv
module imp_addr_ptr #(
    parameter int ADDR_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W/8-1:0]   byte_we,
    input  logic [7:0]            byte_wdata,
    input  logic                  step,
    output logic [ADDR_W-1:0]     ptr
);

    localparam int NB = ADDR_W / 8;

    logic [ADDR_W-1:0] ptr_nxt;

    always_comb begin
        ptr_nxt = ptr;
        if (step) begin
            ptr_nxt = ptr + 1'b1;
        end else begin
            for (int k = 0; k < NB; k++) begin
                if (byte_we[k]) begin
                    ptr_nxt[8*k +: 8] = byte_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_nxt;
        end
    end

endmodule

// File: rtl/imp_chan_bank.sv
module imp_chan_bank
    import imp_pkg::*;
#(
    parameter int NCHAN  = 4,
    parameter int CSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [7:0]        wdata,
    input  logic [CSEL_W-1:0] csel,
    input  logic [NCHAN-1:0]  a2h_raise,
    input  logic [NCHAN-1:0]  h2a_seen,
    output logic [7:0]        ctrl_rd,
    output logic [NCHAN-1:0]  chan_reset,
    output logic [NCHAN-1:0]  chan_halt,
    output logic [NCHAN-1:0]  h2a_irq,
    output logic [NCHAN-1:0]  pend,
    output logic [NCHAN-1:0]  host_irq
);

    logic [7:0] ctrl_byte [NCHAN];

    for (genvar i = 0; i < NCHAN; i++) begin : g_chan
        chan_cfg_t cfg_q;
        logic      pend_q;
        logic      h2a_q;
        logic      hit;

        assign hit = ctrl_we && (csel == CSEL_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q  <= '{rst: 1'b1, halt: 1'b0, irq_en: 1'b0, line_sel: 3'b000};
                pend_q <= 1'b0;
                h2a_q  <= 1'b0;
            end else begin
                if (hit) begin
                    cfg_q <= '{rst: wdata[B_RST], halt: wdata[B_HALT],
                               irq_en: wdata[B_IEN], line_sel: wdata[2:0]};
                end
                // Adapter raise has priority over a host clear.
                if (a2h_raise[i]) begin
                    pend_q <= 1'b1;
                end else if (hit && wdata[B_A2H]) begin
                    pend_q <= 1'b0;
                end
                // Host set has priority over an adapter acknowledge.
                if (hit && wdata[B_H2A]) begin
                    h2a_q <= 1'b1;
                end else if (h2a_seen[i]) begin
                    h2a_q <= 1'b0;
                end
            end
        end

        assign ctrl_byte[i] = {cfg_q.rst, pend_q, h2a_q, cfg_q.halt,
                               cfg_q.irq_en, cfg_q.line_sel};
        assign chan_reset[i] = cfg_q.rst;
        assign chan_halt[i]  = cfg_q.halt;
        assign h2a_irq[i]    = h2a_q;
        assign pend[i]       = pend_q;
        assign host_irq[i]   = pend_q && cfg_q.irq_en && (cfg_q.line_sel != 3'b000);
    end

    assign ctrl_rd = ctrl_byte[csel];

endmodule

// File: rtl/imp_access_seq.sv
module imp_access_seq
    import imp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       mem_ack,
    output logic       accept,
    output logic       data_sel,
    output logic       mem_req,
    output logic       mem_we,
    output logic [7:0] mem_wdata,
    output logic       rd_done,
    output logic       inc_now,
    output logic       hold_now
);

    seq_state_t state_q, state_nxt;
    logic       step_q;
    logic [7:0] wdata_q;
    logic       done;

    assign data_sel = (host_addr == OFF_DATA) || (host_addr == OFF_DATA_INC);

    // State register and access capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_q == ST_IDLE && data_sel && (host_wr || host_rd)) begin
                step_q  <= (host_addr == OFF_DATA_INC);
                wdata_q <= host_wdata;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_wr && data_sel) begin
                    state_nxt = ST_MEM_WR;
                end else if (host_rd && data_sel) begin
                    state_nxt = ST_MEM_RD;
                end
            end
            ST_MEM_RD,
            ST_MEM_WR: begin
                if (mem_ack) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        accept    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept = 1'b1;
            ST_MEM_RD: mem_req = 1'b1;
            ST_MEM_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: accept = 1'b0;
        endcase
        done      = mem_req && mem_ack;
        rd_done   = done && !mem_we;
        inc_now   = done && step_q;
        hold_now  = done && !step_q;
        mem_wdata = wdata_q;
    end

endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
    import imp_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NCHAN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    output logic              host_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    input  logic [NCHAN-1:0]  a2h_raise,
    input  logic [NCHAN-1:0]  h2a_seen,
    output logic [NCHAN-1:0]  chan_reset,
    output logic [NCHAN-1:0]  chan_halt,
    output logic [NCHAN-1:0]  h2a_irq,
    output logic [NCHAN-1:0]  host_irq
);

    localparam int NB     = ADDR_W / 8;
    localparam int CSEL_W = (NCHAN > 1) ? $clog2(NCHAN) : 1;
    localparam int PAD_W  = 8 - NCHAN - CSEL_W;

    logic              accept;
    logic              data_sel;
    logic              rd_done;
    logic              inc_now;
    logic              hold_now;
    logic [ADDR_W-1:0] ptr_q;
    logic [NB-1:0]     byte_we;
    logic [CSEL_W-1:0] csel_q;
    logic [NCHAN-1:0]  pend;
    logic [7:0]        chan_rd;
    logic [7:0]        adp_rd;
    logic [7:0]        reg_mux;
    logic              host_wr_ok;
    logic              host_rd_ok;

    imp_access_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .mem_ack    (mem_ack),
        .accept     (accept),
        .data_sel   (data_sel),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .rd_done    (rd_done),
        .inc_now    (inc_now),
        .hold_now   (hold_now)
    );

    assign host_busy  = !accept;
    assign host_wr_ok = accept && host_wr;
    assign host_rd_ok = accept && host_rd && !host_wr;

    for (genvar k = 0; k < NB; k++) begin : g_addr_we
        assign byte_we[k] = host_wr_ok && (host_addr == 4'(OFF_ADDR0 + k));
    end

    imp_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_we    (byte_we),
        .byte_wdata (host_wdata),
        .step       (inc_now),
        .ptr        (ptr_q)
    );

    assign mem_addr = ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csel_q <= '0;
        end else if (host_wr_ok && host_addr == OFF_ADP) begin
            csel_q <= host_wdata[CSEL_W-1:0];
        end
    end

    imp_chan_bank #(.NCHAN(NCHAN), .CSEL_W(CSEL_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (host_wr_ok && host_addr == OFF_CHAN),
        .wdata      (host_wdata),
        .csel       (csel_q),
        .a2h_raise  (a2h_raise),
        .h2a_seen   (h2a_seen),
        .ctrl_rd    (chan_rd),
        .chan_reset (chan_reset),
        .chan_halt  (chan_halt),
        .h2a_irq    (h2a_irq),
        .pend       (pend),
        .host_irq   (host_irq)
    );

    assign adp_rd = {pend, {PAD_W{1'b0}}, csel_q};

    always_comb begin
        reg_mux = '0;
        for (int k = 0; k < NB; k++) begin
            if (host_addr == 4'(OFF_ADDR0 + k)) begin
                reg_mux = ptr_q[8*k +: 8];
            end
        end
        case (host_addr)
            OFF_ID:   reg_mux = ID_VALUE;
            OFF_CHAN: reg_mux = chan_rd;
            OFF_ADP:  reg_mux = adp_rd;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd_ok && !data_sel) begin
            host_rdata <= reg_mux;
        end else if (rd_done) begin
            host_rdata <= mem_rdata;
        end
    end

endmodule

// File: rtl/imp_regport_chk.sv
module imp_regport_chk #(
    parameter int ADDR_W = 24,
    parameter int NCHAN  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [3:0]        host_addr,
    input logic [7:0]        host_wdata,
    input logic              host_busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic [NCHAN-1:0]  h2a_irq,
    input logic [ADDR_W-1:0] ptr,
    input logic              inc_now,
    input logic              hold_now
);

    // R5: request fields hold until acknowledged
    a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R5: busy covers every outstanding request
    a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> host_busy);

    // R3: fixed-pointer access leaves the pointer alone
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_now |=> (ptr == $past(ptr)));

    // R4: incrementing access advances the pointer by one, with wrap
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc_now |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    // R8: a doorbell rises only after a host write with bit 5 set
    a_r8_h2a_from_host: assert property (@(posedge clk) disable iff (!rst_n)
        ((h2a_irq & ~$past(h2a_irq)) != '0) |->
            $past(host_wr && host_addr == 4'd1 && host_wdata[5]));

endmodule

bind ind_mem_port imp_regport_chk #(.ADDR_W(ADDR_W), .NCHAN(NCHAN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_busy  (host_busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .h2a_irq    (h2a_irq),
    .ptr        (ptr_q),
    .inc_now    (inc_now),
    .hold_now   (hold_now)
);

// File: tb/ind_mem_port_tb.sv
module ind_mem_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        host_busy;
    logic        mem_req;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [3:0]  a2h_raise = '0;
    logic [3:0]  h2a_seen = '0;
    logic [3:0]  chan_reset, chan_halt, h2a_irq, host_irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ind_mem_port u_dut (.*);

    // Memory model: acknowledges two cycles after a request appears.
    logic [7:0] mem [256];
    int         lat = 0;
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (lat == 1) begin
                lat     <= 0;
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:0]];
            end else begin
                lat <= lat + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (host_busy) @(negedge clk);
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        wait_idle();
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
        wait_idle();
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] d);
        wait_idle();
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        @(negedge clk);
        wait_idle();
        d = host_rdata;
    endtask

    task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        hread(a, v);
        chk(req, {24'h0, v}, {24'h0, exp});
    endtask

    // {req number, is_read, offset, write data, expected read data}
    localparam int NV = 37;
    localparam logic [24:0] VEC [NV] = '{
        {4'd2,  1'b0, 4'h2, 8'h10, 8'h00},  // R2
        {4'd2,  1'b0, 4'h3, 8'h00, 8'h00},
        {4'd2,  1'b0, 4'h4, 8'h00, 8'h00},
        {4'd2,  1'b1, 4'h2, 8'h00, 8'h10},
        {4'd4,  1'b0, 4'h6, 8'h11, 8'h00},  // R4 streamed writes
        {4'd4,  1'b0, 4'h6, 8'h22, 8'h00},
        {4'd4,  1'b0, 4'h6, 8'h33, 8'h00},
        {4'd4,  1'b1, 4'h2, 8'h00, 8'h13},
        {4'd2,  1'b0, 4'h2, 8'h10, 8'h00},
        {4'd3,  1'b1, 4'h5, 8'h00, 8'h11},  // R3 fixed pointer
        {4'd3,  1'b1, 4'h5, 8'h00, 8'h11},
        {4'd3,  1'b1, 4'h2, 8'h00, 8'h10},
        {4'd4,  1'b1, 4'h6, 8'h00, 8'h11},
        {4'd4,  1'b1, 4'h6, 8'h00, 8'h22},
        {4'd4,  1'b1, 4'h6, 8'h00, 8'h33},
        {4'd4,  1'b1, 4'h2, 8'h00, 8'h13},
        {4'd2,  1'b0, 4'h2, 8'hFF, 8'h00},
        {4'd2,  1'b0, 4'h3, 8'hFF, 8'h00},
        {4'd2,  1'b0, 4'h4, 8'hFF, 8'h00},
        {4'd2,  1'b1, 4'h4, 8'h00, 8'hFF},
        {4'd2,  1'b1, 4'h3, 8'h00, 8'hFF},
        {4'd4,  1'b0, 4'h6, 8'h5A, 8'h00},  // R4 wrap
        {4'd4,  1'b1, 4'h2, 8'h00, 8'h00},
        {4'd4,  1'b1, 4'h3, 8'h00, 8'h00},
        {4'd4,  1'b1, 4'h4, 8'h00, 8'h00},
        {4'd4,  1'b0, 4'h2, 8'hFF, 8'h00},
        {4'd4,  1'b1, 4'h5, 8'h00, 8'h5A},
        {4'd1,  1'b1, 4'h0, 8'h00, 8'hA4},  // R1
        {4'd1,  1'b0, 4'h7, 8'h55, 8'h00},
        {4'd1,  1'b1, 4'h7, 8'h00, 8'h00},
        {4'd1,  1'b1, 4'h9, 8'h00, 8'h00},
        {4'd10, 1'b0, 4'h8, 8'hFE, 8'h00},  // R10
        {4'd10, 1'b1, 4'h8, 8'h00, 8'h02},
        {4'd10, 1'b0, 4'h8, 8'h00, 8'h00},
        {4'd6,  1'b1, 4'h1, 8'h00, 8'h80},  // R6
        {4'd9,  1'b0, 4'h1, 8'h1D, 8'h00},  // R9
        {4'd9,  1'b1, 4'h1, 8'h00, 8'h1D}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R6, R8, R9, R5)
        chk("R6 reset", {28'h0, chan_reset}, 32'hF);
        chk("R9 reset halt", {28'h0, chan_halt}, 32'h0);
        chk("R8 reset", {28'h0, h2a_irq}, 32'h0);
        chk("R9 reset irq", {28'h0, host_irq}, 32'h0);
        chk("R5 reset", {30'h0, mem_req, host_busy}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                hread(VEC[i][19:16], v);
                checks++;
                if (v !== VEC[i][7:0]) begin
                    failures++;
                    $display("FAIL R%0d vec %0d actual=%h expected=%h",
                             VEC[i][24:21], i, v, VEC[i][7:0]);
                end
            end else begin
                hwrite(VEC[i][19:16], VEC[i][15:8]);
            end
        end

        // R9 outputs from channel 0 settings
        chk("R9 halt out", {28'h0, chan_halt}, 32'h1);
        chk("R6 reset out", {28'h0, chan_reset}, 32'hE);

        // R6 banking
        hwrite(4'h8, 8'h02);
        hwrite(4'h1, 8'h00);
        chk("R6 bank ch2", {28'h0, chan_reset}, 32'hA);
        rchk("R6 ch2 read", 4'h1, 8'h00);
        hwrite(4'h8, 8'h00);
        rchk("R6 ch0 kept", 4'h1, 8'h1D);

        // R7 / R11 adapter-to-host flag
        hwrite(4'h8, 8'h02);
        a2h_raise = 4'b0100; @(negedge clk); a2h_raise = '0;
        rchk("R11 summary", 4'h8, 8'h42);
        rchk("R7 flag set", 4'h1, 8'h40);
        chk("R9 gated off", {28'h0, host_irq}, 32'h0);
        hwrite(4'h1, 8'h09);
        rchk("R7 write0 keeps", 4'h1, 8'h49);
        chk("R9 irq out", {28'h0, host_irq}, 32'h4);
        hwrite(4'h8, 8'h02);
        rchk("R11 write ignored", 4'h8, 8'h42);
        // raise and clear in the same cycle: raise wins (R7)
        host_addr = 4'h1; host_wdata = 8'h49; host_wr = 1'b1; a2h_raise = 4'b0100;
        @(negedge clk);
        host_wr = 1'b0; a2h_raise = '0;
        rchk("R7 set wins", 4'h1, 8'h49);
        hwrite(4'h1, 8'h49);
        rchk("R7 cleared", 4'h1, 8'h09);
        rchk("R11 cleared", 4'h8, 8'h02);
        chk("R9 irq drop", {28'h0, host_irq}, 32'h0);

        // R8 doorbell
        hwrite(4'h8, 8'h01);
        hwrite(4'h1, 8'h20);
        chk("R8 raised", {28'h0, h2a_irq}, 32'h2);
        rchk("R8 read set", 4'h1, 8'h20);
        hwrite(4'h1, 8'h00);
        rchk("R8 write0 keeps", 4'h1, 8'h20);
        h2a_seen = 4'b0010; @(negedge clk); h2a_seen = '0;
        rchk("R8 seen", 4'h1, 8'h00);
        chk("R8 out clear", {28'h0, h2a_irq}, 32'h0);

        // R5 busy window and ignored strobe
        hwrite(4'h2, 8'h56);
        hwrite(4'h3, 8'h34);
        hwrite(4'h4, 8'h12);
        host_addr = 4'h5; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk("R5 busy", {30'h0, host_busy, mem_req}, 32'h3);
        chk("R5 addr", {8'h0, mem_addr}, 32'h123456);
        chk("R5 read dir", {31'h0, mem_we}, 32'h0);
        host_addr = 4'h2; host_wdata = 8'h77; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        wait_idle();
        rchk("R5 strobe ignored", 4'h2, 8'h56);

        // R12 register read latency
        rchk("R12 prep", 4'h7, 8'h00);
        host_addr = 4'h0; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk("R12 one edge", {24'h0, host_rdata}, 32'hA4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule